// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the finite-state controller of a multicycle load/store processor datapath. Each instruction is carried through a series of clock cycles; in each cycle the sequencer drives the datapath's control lines: memory read and write strobes, the memory address source, the instruction register load, the register file write and its destination and write-back sources, the ALU operand and operation selects, and the program counter source and write enable. Every instruction starts with the same two cycles. The first fetches the instruction and advances the PC by 4. The second decodes the instruction and reads the registers. The opcode seen in the decode cycle then picks a sequence of one to three execution cycles for the instruction's class.

The surrounding datapath holds the instruction register and presents its opcode and function fields as plain inputs, together with the ALU zero flag. No data streams through the block, so it has no valid/ready handshake. Every pin is a level-sensitive control or status signal that is valid for one cycle at a time, and the datapath cannot stall the sequencer. A one-cycle retire pulse marks the last cycle of every completed instruction.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While `rst` is high, every output is 0. Reset is synchronous. The first cycle after `rst` is released is a fetch cycle, including when reset lands in the middle of an instruction.
- R2: A fetch cycle drives mem_rd=1, addr_sel=0, ir_ld=1, alu_a_sel=0, alu_b_sel=1 (constant 4), alu_op=0 (add), pc_src=0 (ALU result) and pc_we=1. The cycle after it is always decode, which drives alu_a_sel=0, alu_b_sel=3 (shifted immediate), alu_op=0 and no write or read enable.
- R3: Opcode 6'h23 (load) takes 5 cycles. The execution cycles are: address (alu_a_sel=1, alu_b_sel=2, add); memory read (mem_rd=1, addr_sel=1); register write (rf_wr=1, wb_sel=1 memory data, reg_dst=0, retire=1).
- R4: Opcode 6'h2B (store) takes 4 cycles. The execution cycles are: address (as in R3), then memory write (mem_wr=1, addr_sel=1, retire=1).
- R5: Opcode 6'h00 (register-register) takes 4 cycles. The first execution cycle drives alu_a_sel=1 and alu_b_sel=0, with alu_op decoded from funct: 6'h20→0 add, 6'h22→1 sub, 6'h24→2 and, 6'h25→3 or, 6'h2A→4 set-less-than, any other value→0. The second drives rf_wr=1, wb_sel=0, reg_dst=1 and retire=1.
- R6: Opcode 6'h04 (branch if equal) takes 3 cycles. Its last cycle drives alu_a_sel=1, alu_b_sel=0, alu_op=1, pc_src=1 (branch target) and retire=1, with pc_we equal to alu_zero.
- R7: Opcode 6'h05 (branch if not equal) has the same cycles as R6, except that pc_we equals the inverse of alu_zero.
- R8: Opcode 6'h02 (jump) takes 3 cycles. Its last cycle drives pc_src=2, pc_we=1 and retire=1.
- R9: Any other opcode goes from decode straight back to fetch. It asserts no write enable and no retire.
- R10: retire is high for exactly one cycle per completed instruction, in its last cycle, and the next cycle is a fetch. mem_rd and mem_wr are never high together.
- R11: opcode is used only in the decode cycle, funct only in the register-register execution cycle, and alu_zero only in the branch cycle. Their values in any other cycle change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_ld | output | 1 | Instruction register load |
| rf_wr | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination register: 0 rt field, 1 rd field |
| wb_sel | output | 1 | Write-back data: 0 ALU output, 1 memory data |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 0 reg B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 set-less-than |
| pc_src | output | 2 | Next PC: 0 ALU result, 1 branch target register, 2 jump target |
| pc_we | output | 1 | PC write enable |
| retire | output | 1 | Last cycle of an instruction |

## Verification
The bench runs one instruction of every class and compares all control lines on every cycle against a behavioural per-class model. A wrong cycle count or a class routed into a neighbour's sequence shows up as a mismatch in a single cycle. Both branch opcodes are tried with the zero flag at 0 and at 1, which separates the equal and not-equal conditions and exposes an unconditional PC write. Every register-register function code, plus an undefined one, is run to check the operation decode. Outside the cycle that is allowed to use them, the opcode, funct and zero inputs are driven with inverted garbage, which exposes any late sampling. A reset in the middle of a load and two illegal opcodes check the recovery paths back to fetch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int AOP_W = 3;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_LADDR, ST_MRD, ST_LDWB, ST_SADDR,
    ST_MWR, ST_REXE, ST_RWB, ST_BEQ, ST_BNE, ST_JMP
  } mcs_state_e;

  typedef enum logic [2:0] {
    CLS_LOAD, CLS_STORE, CLS_RTYPE, CLS_BEQ, CLS_BNE, CLS_JUMP, CLS_NONE
  } mcs_class_e;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE   = 6'h05;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [AOP_W-1:0] AOP_ADD = 3'd0;
  localparam logic [AOP_W-1:0] AOP_SUB = 3'd1;
  localparam logic [AOP_W-1:0] AOP_AND = 3'd2;
  localparam logic [AOP_W-1:0] AOP_OR  = 3'd3;
  localparam logic [AOP_W-1:0] AOP_SLT = 3'd4;

  localparam logic [1:0] BSRC_REG  = 2'd0;
  localparam logic [1:0] BSRC_FOUR = 2'd1;
  localparam logic [1:0] BSRC_IMM  = 2'd2;
  localparam logic [1:0] BSRC_IMMS = 2'd3;

  localparam logic [1:0] PSRC_ALU = 2'd0;
  localparam logic [1:0] PSRC_TGT = 2'd1;
  localparam logic [1:0] PSRC_JMP = 2'd2;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             addr_sel;
    logic             ir_ld;
    logic             rf_wr;
    logic             reg_dst;
    logic             wb_sel;
    logic             alu_a_sel;
    logic [1:0]       alu_b_sel;
    logic [AOP_W-1:0] alu_op;
    logic [1:0]       pc_src;
    logic             pc_we;
    logic             retire;
  } mcs_ctl_t;
endpackage

// File: rtl/mcs_class_dec.sv
module mcs_class_dec
  import mcs_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output mcs_class_e       cls
);
  always_comb begin
    case (opcode)
      OPC_LOAD:  cls = CLS_LOAD;
      OPC_STORE: cls = CLS_STORE;
      OPC_RTYPE: cls = CLS_RTYPE;
      OPC_BEQ:   cls = CLS_BEQ;
      OPC_BNE:   cls = CLS_BNE;
      OPC_JUMP:  cls = CLS_JUMP;
      default:   cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/mcs_alu_fn.sv
module mcs_alu_fn
  import mcs_pkg::*;
(
  input  logic [FN_W-1:0]  funct,
  output logic [AOP_W-1:0] aop
);
  always_comb begin
    case (funct)
      FN_SUB:  aop = AOP_SUB;
      FN_AND:  aop = AOP_AND;
      FN_OR:   aop = AOP_OR;
      FN_SLT:  aop = AOP_SLT;
      FN_ADD:  aop = AOP_ADD;
      default: aop = AOP_ADD;
    endcase
  end
endmodule

// File: rtl/mcs_ctl_gen.sv
module mcs_ctl_gen
  import mcs_pkg::*;
(
  input  mcs_state_e       state,
  input  logic [AOP_W-1:0] r_aop,
  input  logic             alu_zero,
  output mcs_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    case (state)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_ld     = 1'b1;
        ctl.alu_b_sel = BSRC_FOUR;
        ctl.alu_op    = AOP_ADD;
        ctl.pc_src    = PSRC_ALU;
        ctl.pc_we     = 1'b1;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = BSRC_IMMS;
        ctl.alu_op    = AOP_ADD;
      end
      ST_LADDR, ST_SADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSRC_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      ST_MRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.wb_sel = 1'b1;
        ctl.retire = 1'b1;
      end
      ST_MWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
        ctl.retire   = 1'b1;
      end
      ST_REXE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSRC_REG;
        ctl.alu_op    = r_aop;
      end
      ST_RWB: begin
        ctl.rf_wr   = 1'b1;
        ctl.reg_dst = 1'b1;
        ctl.retire  = 1'b1;
      end
      ST_BEQ, ST_BNE: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSRC_REG;
        ctl.alu_op    = AOP_SUB;
        ctl.pc_src    = PSRC_TGT;
        ctl.pc_we     = (state == ST_BEQ) ? alu_zero : !alu_zero;
        ctl.retire    = 1'b1;
      end
      ST_JMP: begin
        ctl.pc_src = PSRC_JMP;
        ctl.pc_we  = 1'b1;
        ctl.retire = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             alu_zero,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_ld,
  output logic             rf_wr,
  output logic             reg_dst,
  output logic             wb_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [AOP_W-1:0] alu_op,
  output logic [1:0]       pc_src,
  output logic             pc_we,
  output logic             retire
);
  mcs_state_e       state_q, state_d;
  mcs_class_e       cls;
  logic [AOP_W-1:0] r_aop;
  mcs_ctl_t         ctl, ctl_o;

  mcs_class_dec u_dec (.opcode(opcode), .cls(cls));
  mcs_alu_fn    u_fn  (.funct(funct), .aop(r_aop));
  mcs_ctl_gen   u_gen (.state(state_q), .r_aop(r_aop), .alu_zero(alu_zero), .ctl(ctl));

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CLS_LOAD:  state_d = ST_LADDR;
          CLS_STORE: state_d = ST_SADDR;
          CLS_RTYPE: state_d = ST_REXE;
          CLS_BEQ:   state_d = ST_BEQ;
          CLS_BNE:   state_d = ST_BNE;
          CLS_JUMP:  state_d = ST_JMP;
          default:   state_d = ST_FETCH;
        endcase
      end
      ST_LADDR:  state_d = ST_MRD;
      ST_MRD:    state_d = ST_LDWB;
      ST_SADDR:  state_d = ST_MWR;
      ST_REXE:   state_d = ST_RWB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    ctl_o = rst ? '0 : ctl;
  end

  assign mem_rd    = ctl_o.mem_rd;
  assign mem_wr    = ctl_o.mem_wr;
  assign addr_sel  = ctl_o.addr_sel;
  assign ir_ld     = ctl_o.ir_ld;
  assign rf_wr     = ctl_o.rf_wr;
  assign reg_dst   = ctl_o.reg_dst;
  assign wb_sel    = ctl_o.wb_sel;
  assign alu_a_sel = ctl_o.alu_a_sel;
  assign alu_b_sel = ctl_o.alu_b_sel;
  assign alu_op    = ctl_o.alu_op;
  assign pc_src    = ctl_o.pc_src;
  assign pc_we     = ctl_o.pc_we;
  assign retire    = ctl_o.retire;
endmodule

// File: rtl/mc_ctrl_seq_chk.sv
module mc_ctrl_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       addr_sel,
  input logic       ir_ld,
  input logic       rf_wr,
  input logic       wb_sel,
  input logic [1:0] pc_src,
  input logic       pc_we,
  input logic       retire
);
  // R1: all enables quiet while reset is held
  always_comb begin
    if (rst) begin
      a_r1_quiet_in_reset: assert (!(mem_rd || mem_wr || ir_ld || rf_wr || pc_we || retire));
    end
  end

  // R1: fetch right after reset release
  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ir_ld);

  // R2: the cycle after a fetch writes nothing
  a_r2_decode_quiet: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> !(ir_ld || mem_rd || mem_wr || rf_wr || pc_we || retire));

  // R10: retire is followed by a fetch
  a_r10_retire_then_fetch: assert property (@(posedge clk) disable iff (rst)
    retire |=> ir_ld);

  // R10: no simultaneous memory read and write
  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R3: a memory-data write-back follows a data read
  a_r3_load_wb_after_read: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && wb_sel) |-> $past(mem_rd && addr_sel));

  // R4: a memory write is the last cycle of a store
  a_r4_store_retires: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> retire);

  // R6: a taken-branch PC write is the last cycle
  a_r6_branch_retires: assert property (@(posedge clk) disable iff (rst)
    (pc_we && pc_src == 2'd1) |-> retire);
endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk i_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
  .ir_ld(ir_ld), .rf_wr(rf_wr), .wb_sel(wb_sel), .pc_src(pc_src),
  .pc_we(pc_we), .retire(retire)
);

// File: tb/test_mc_ctrl_seq.sv
module test_mc_ctrl_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h00;
  logic       alu_zero = 1'b0;
  logic       mem_rd, mem_wr, addr_sel, ir_ld, rf_wr, reg_dst, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, pc_src;
  logic [2:0] alu_op;
  logic       pc_we, retire;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mc_ctrl_seq i_mc_ctrl_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_ld(ir_ld),
    .rf_wr(rf_wr), .reg_dst(reg_dst), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src), .pc_we(pc_we),
    .retire(retire)
  );

  wire [17:0] got = {mem_rd, mem_wr, addr_sel, ir_ld, rf_wr, reg_dst, wb_sel,
                     alu_a_sel, alu_b_sel, alu_op, pc_src, pc_we, retire};

  function automatic logic [17:0] mk(bit mrd, bit mwr, bit asel, bit ir, bit rfw,
      bit rdst, bit wbs, bit asrc, logic [1:0] bsrc, logic [2:0] op,
      logic [1:0] psrc, bit pcw, bit ret);
    return {mrd, mwr, asel, ir, rfw, rdst, wbs, asrc, bsrc, op, psrc, pcw, ret};
  endfunction

  function automatic logic [2:0] fn_op(logic [5:0] fn);
    case (fn)
      6'h22:   return 3'd1;
      6'h24:   return 3'd2;
      6'h25:   return 3'd3;
      6'h2A:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(string req, logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: drive at the negedge, compare, move to the next negedge
  task automatic cyc(string req, logic [17:0] exp, logic [5:0] op, logic [5:0] fn, logic z);
    opcode = op; funct = fn; alu_zero = z;
    #1;
    check(req, exp);
    @(negedge clk);
  endtask

  // Behavioural reference: expected words per cycle for one instruction.
  // Inputs outside their sampling cycle get inverted garbage (R11).
  task automatic run(logic [5:0] op, logic [5:0] fn, logic z);
    logic [17:0] q[$];
    string       lab[$];
    int          fexe;
    int          zcyc;
    fexe = -1; zcyc = -1;
    q.push_back(mk(1,0,0,1,0,0,0,0,2'd1,3'd0,2'd0,1,0)); lab.push_back("R2 fetch");
    q.push_back(mk(0,0,0,0,0,0,0,0,2'd3,3'd0,2'd0,0,0)); lab.push_back("R2 decode");
    case (op)
      6'h23: begin
        q.push_back(mk(0,0,0,0,0,0,0,1,2'd2,3'd0,2'd0,0,0)); lab.push_back("R3/R11 load addr");
        q.push_back(mk(1,0,1,0,0,0,0,0,2'd0,3'd0,2'd0,0,0)); lab.push_back("R3/R11 load read");
        q.push_back(mk(0,0,0,0,1,0,1,0,2'd0,3'd0,2'd0,0,1)); lab.push_back("R3/R10 load wb");
      end
      6'h2B: begin
        q.push_back(mk(0,0,0,0,0,0,0,1,2'd2,3'd0,2'd0,0,0)); lab.push_back("R4/R11 store addr");
        q.push_back(mk(0,1,1,0,0,0,0,0,2'd0,3'd0,2'd0,0,1)); lab.push_back("R4/R10 store write");
      end
      6'h00: begin
        fexe = q.size();
        q.push_back(mk(0,0,0,0,0,0,0,1,2'd0,fn_op(fn),2'd0,0,0)); lab.push_back("R5 rtype exe");
        q.push_back(mk(0,0,0,0,1,1,0,0,2'd0,3'd0,2'd0,0,1)); lab.push_back("R5/R11 rtype wb");
      end
      6'h04: begin
        zcyc = q.size();
        q.push_back(mk(0,0,0,0,0,0,0,1,2'd0,3'd1,2'd1,z,1)); lab.push_back("R6 beq");
      end
      6'h05: begin
        zcyc = q.size();
        q.push_back(mk(0,0,0,0,0,0,0,1,2'd0,3'd1,2'd1,!z,1)); lab.push_back("R7 bne");
      end
      6'h02: begin
        q.push_back(mk(0,0,0,0,0,0,0,0,2'd0,3'd0,2'd2,1,1)); lab.push_back("R8 jump");
      end
      default: lab[1] = "R9 illegal decode";
    endcase
    for (int i = 0; i < q.size(); i++) begin
      cyc(lab[i], q[i], (i == 1) ? op : ~op, (i == fexe) ? fn : ~fn,
          (i == zcyc) ? z : ~z);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    cyc("R1 reset outputs", 18'h0, 6'h23, 6'h20, 1'b1);
    cyc("R1 reset outputs", 18'h0, 6'h04, 6'h22, 1'b0);
    rst = 1'b0;

    run(6'h23, 6'h00, 1'b0);  // load
    run(6'h2B, 6'h00, 1'b1);  // store
    run(6'h00, 6'h20, 1'b0);  // add
    run(6'h00, 6'h22, 1'b1);  // sub
    run(6'h00, 6'h24, 1'b0);  // and
    run(6'h00, 6'h25, 1'b0);  // or
    run(6'h00, 6'h2A, 1'b0);  // slt
    run(6'h00, 6'h07, 1'b0);  // undefined funct -> add
    run(6'h04, 6'h00, 1'b1);  // beq taken
    run(6'h04, 6'h00, 1'b0);  // beq not taken
    run(6'h05, 6'h00, 1'b1);  // bne not taken
    run(6'h05, 6'h00, 1'b0);  // bne taken
    run(6'h02, 6'h00, 1'b0);  // jump
    run(6'h3F, 6'h00, 1'b0);  // illegal
    run(6'h01, 6'h00, 1'b1);  // illegal
    run(6'h2B, 6'h00, 1'b0);  // store after illegal

    // R1: reset in the middle of a load, then a store from fetch
    cyc("R2 fetch", mk(1,0,0,1,0,0,0,0,2'd1,3'd0,2'd0,1,0), 6'h00, 6'h00, 1'b0);
    cyc("R2 decode", mk(0,0,0,0,0,0,0,0,2'd3,3'd0,2'd0,0,0), 6'h23, 6'h00, 1'b0);
    cyc("R3 load addr", mk(0,0,0,0,0,0,0,1,2'd2,3'd0,2'd0,0,0), 6'h23, 6'h00, 1'b0);
    rst = 1'b1;
    cyc("R1 mid-instruction reset", 18'h0, 6'h23, 6'h00, 1'b0);
    rst = 1'b0;
    run(6'h2B, 6'h00, 1'b0);
    run(6'h23, 6'h00, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule